// File: doc/BRIEF.md
# SPI FIFO DMA Request Controller

This block sits beside the transmit and receive FIFOs of a serial peripheral and decides when a DMA engine should be asked to move data. It watches the occupancy count of each FIFO and derives four status flags from it: the transmit side has room for a burst, the transmit side has run dry, the receive side is full, and the receive side holds a burst worth of words. Each flag drives one DMA request line, and each line can be switched on or off on its own.

Software sees one 32-bit word through a plain write strobe and a read data bus. The word holds four read/write enable bits and the four live status flags. All other bits read as zero. The request outputs are registered, so they follow the FIFO counts and enables one clock later. The empty flag on the transmit side reports only the FIFO. It does not show whether the shifter is still sending the last word.

Top module: `spi_dma_ctrl`

## Requirements
- R1: After reset all four enables are 0 and all four request outputs are 0. With a transmit count of 8 and a receive count of 0, `reg_rdata` reads 0x00000000.
- R2: A write with `reg_wr`=1 stores `reg_wdata[15:12]` as the enables, which apply from the next clock. Bit 15 enables transmit half-empty, bit 14 transmit empty, bit 13 receive full and bit 12 receive half-full. The stored enables read back in the same bit positions.
- R3: Status bit 7 is 1 when the transmit FIFO has at least 4 free slots (8 minus `tx_count` is 4 or more), and 0 otherwise.
- R4: Status bit 6 is 1 exactly when `tx_count` is 0.
- R5: Status bit 5 is 1 exactly when `rx_count` is 8.
- R6: Status bit 4 is 1 when `rx_count` is 4 or more.
- R7: Bits 31:16, 11:8 and 3:0 always read 0, whatever was written to them.
- R8: Writes to status bits 7:4 have no effect. Those bits always show the live flags.
- R9: Each request output equals its status flag ANDed with its enable bit, both taken before the clock edge. The output is registered and shows the result from that edge on.
- R10: A request whose enable bit is 0 stays low even while its flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronized inside the block. |
| tx_count | input | 4 | Number of words in the transmit FIFO (0 to 8) |
| rx_count | input | 4 | Number of words in the receive FIFO (0 to 8) |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data: enables in 15:12, live flags in 7:4 |
| dma_req_tx_half | output | 1 | Request: transmit FIFO has room for a burst |
| dma_req_tx_empty | output | 1 | Request: transmit FIFO is empty |
| dma_req_rx_full | output | 1 | Request: receive FIFO is full |
| dma_req_rx_half | output | 1 | Request: receive FIFO holds a burst |

## Verification
The bench builds the block with its default depth of 8, so the burst mark is 4 and the count inputs are 4 bits wide. With these values both sides of every threshold can be driven: transmit counts 4 and 5 straddle the free-slot mark, counts 0 and 1 straddle empty, and receive counts 3, 4, 7 and 8 cover half-full and full. Partial enable patterns, and status bits written alongside the enables, check that each request is gated only by its own enable.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  // Order of fields sets the bit order in the read word (7..4) and request vector (3..0).
  typedef struct packed {
    logic tx_half;
    logic tx_empty;
    logic rx_full;
    logic rx_half;
  } dma_flags_t;

  localparam int REG_W    = 32;
  localparam int EN_LSB   = 12;
  localparam int FLAG_LSB = 4;
  localparam int N_REQ    = 4;
endpackage

// File: rtl/spi_dma_rst_sync.sv
module spi_dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spi_dma_flags.sv
module spi_dma_flags
  import spi_dma_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HALF_MARK = DEPTH / 2,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  output dma_flags_t       flags
);
  // At least HALF_MARK free slots <=> count <= DEPTH - HALF_MARK (no subtraction underflow).
  localparam logic [CNT_W-1:0] TX_ROOM_MAX = CNT_W'(DEPTH - HALF_MARK);
  localparam logic [CNT_W-1:0] FULL_CNT    = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT    = CNT_W'(HALF_MARK);

  always_comb begin
    flags.tx_half  = (tx_count <= TX_ROOM_MAX);
    flags.tx_empty = (tx_count == '0);
    flags.rx_full  = (rx_count == FULL_CNT);
    flags.rx_half  = (rx_count >= HALF_CNT);
  end
endmodule

// File: rtl/spi_dma_enreg.sv
module spi_dma_enreg
  import spi_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_REQ-1:0] wr_val,
  output logic [N_REQ-1:0] en_q
);
  logic [N_REQ-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/spi_dma_reqgen.sv
module spi_dma_reqgen
  import spi_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dma_flags_t       flags,
  input  logic [N_REQ-1:0] en,
  output logic [N_REQ-1:0] req_q
);
  logic [N_REQ-1:0] flag_vec;
  assign flag_vec = flags;

  for (genvar g = 0; g < N_REQ; g++) begin : g_lane
    logic lane_d;
    always_comb begin
      lane_d = flag_vec[g] & en[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[g] <= 1'b0;
      else        req_q[g] <= lane_d;
    end
  end
endmodule

// File: rtl/spi_dma_ctrl.sv
module spi_dma_ctrl
  import spi_dma_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HALF_MARK = DEPTH / 2,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             dma_req_tx_half,
  output logic             dma_req_tx_empty,
  output logic             dma_req_rx_full,
  output logic             dma_req_rx_half
);
  logic             rst_int_n;
  dma_flags_t       flags;
  logic [N_REQ-1:0] en_q;
  logic [N_REQ-1:0] req_q;

  spi_dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  spi_dma_flags #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK), .CNT_W(CNT_W)) u_flags (
    .tx_count(tx_count), .rx_count(rx_count), .flags(flags)
  );

  spi_dma_enreg u_en (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr),
    .wr_val(reg_wdata[EN_LSB +: N_REQ]), .en_q(en_q)
  );

  spi_dma_reqgen u_req (
    .clk(clk), .rst_n(rst_int_n), .flags(flags), .en(en_q), .req_q(req_q)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[EN_LSB +: N_REQ]   = en_q;
    reg_rdata[FLAG_LSB +: N_REQ] = flags;
  end

  assign {dma_req_tx_half, dma_req_tx_empty, dma_req_rx_full, dma_req_rx_half} = req_q;
endmodule

// File: rtl/spi_dma_ctrl_chk.sv
module spi_dma_ctrl_chk #(
  parameter int DEPTH     = 8,
  parameter int HALF_MARK = DEPTH / 2,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             dma_req_tx_half,
  input logic             dma_req_tx_empty,
  input logic             dma_req_rx_full,
  input logic             dma_req_rx_half
);
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:16] == '0) && (reg_rdata[11:8] == '0) && (reg_rdata[3:0] == '0));

  assert_tx_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == ((DEPTH - int'(tx_count)) >= HALF_MARK));

  assert_tx_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] == (tx_count == '0));

  assert_rx_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] == (int'(rx_count) == DEPTH));

  assert_rx_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] == (int'(rx_count) >= HALF_MARK));

  assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(reg_rdata[15:12]));

  assert_gate_tx_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dma_req_tx_half == $past(reg_rdata[15] & reg_rdata[7]));

  assert_gate_tx_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dma_req_tx_empty == $past(reg_rdata[14] & reg_rdata[6]));

  assert_gate_rx_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dma_req_rx_full == $past(reg_rdata[13] & reg_rdata[5]));

  assert_gate_rx_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dma_req_rx_half == $past(reg_rdata[12] & reg_rdata[4]));

  assert_disabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[15] |=> !dma_req_tx_half);
endmodule

bind spi_dma_ctrl spi_dma_ctrl_chk #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .dma_req_tx_half(dma_req_tx_half), .dma_req_tx_empty(dma_req_tx_empty),
  .dma_req_rx_full(dma_req_rx_full), .dma_req_rx_half(dma_req_rx_half)
);

// File: tb/sim_spi_dma_ctrl.sv
`timescale 1ns/1ps
module sim_spi_dma_ctrl;
  logic        clk;
  logic        rst_n;
  logic [3:0]  tx_count;
  logic [3:0]  rx_count;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rq_txh, rq_txe, rq_rxf, rq_rxh;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] rdata;
    logic [3:0]  req;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [3:0] en_model;

  spi_dma_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_req_tx_half(rq_txh), .dma_req_tx_empty(rq_txe),
    .dma_req_rx_full(rq_rxf), .dma_req_rx_half(rq_rxh)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [3:0] model_flags(input int tx, input int rx);
    return {(8 - tx) >= 4, tx == 0, rx == 8, rx >= 4};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: req/rdata actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected outcome.
  task automatic step(input int tx, input int rx, input bit wr, input logic [31:0] wd, input string tag);
    exp_t e;
    logic [3:0] f;
    @(negedge clk);
    tx_count = 4'(tx); rx_count = 4'(rx); reg_wr = wr; reg_wdata = wd;
    f = model_flags(tx, rx);
    e.req = f & en_model;
    if (wr) en_model = wd[15:12];
    e.rdata = {16'h0, en_model, 4'h0, f, 4'h0};
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare after each clock edge once the outputs have settled.
  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, {rq_txh, rq_txe, rq_rxf, rq_rxh, reg_rdata}, {e.req, e.rdata});
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    en_model = 4'h0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    tx_count = 4'd8; rx_count = 4'd0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", {rq_txh, rq_txe, rq_rxf, rq_rxh, reg_rdata}, 36'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1", {rq_txh, rq_txe, rq_rxf, rq_rxh, reg_rdata}, 36'h0);

    // R2 R7 R8: all ones written, only enables stick
    step(8, 0, 1, 32'hFFFF_FFFF, "R2");
    step(8, 0, 0, 32'h0, "R7");
    // R3 boundary of free slots
    step(4, 0, 0, 32'h0, "R3");
    step(5, 0, 0, 32'h0, "R3");
    step(4, 0, 0, 32'h0, "R9");
    // R4 empty boundary
    step(0, 0, 0, 32'h0, "R4");
    step(1, 0, 0, 32'h0, "R4");
    // R6 and R5 receive thresholds
    step(8, 3, 0, 32'h0, "R6");
    step(8, 4, 0, 32'h0, "R6");
    step(8, 7, 0, 32'h0, "R5");
    step(8, 8, 0, 32'h0, "R5");
    // R10 partial enables, status bits in write ignored (R8)
    step(0, 8, 1, 32'h0000_50F0, "R8");
    step(0, 8, 0, 32'h0, "R10");
    step(0, 8, 0, 32'h0, "R10");
    // R9 disable all, requests drop one cycle later
    step(0, 8, 1, 32'h0, "R9");
    step(0, 8, 0, 32'h0, "R9");
    step(3, 5, 1, 32'h0000_3000, "R2");
    step(3, 5, 0, 32'h0, "R9");
    step(6, 8, 0, 32'h0, "R9");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule